// File: doc/BRIEF.md
# PCI Interrupt Line Steering Router

This block sits between eight shared PCI interrupt request lines and the sixteen request inputs of a legacy interrupt controller. The PCI lines are active low and level sensitive, so several devices can pull the same wire. Each line has a byte-wide route register. The register either names one of the sixteen IRQ inputs as the line's target or turns steering off for that line. Several lines may name the same IRQ, and their requests are then ORed onto that input. Each steered line is inverted, so the controller sees an active-high level.

Any IRQ that an enabled route targets is claimed by PCI. The request from the legacy device on that IRQ is then dropped, and the claim mask is driven out so the rest of the chip can see which inputs PCI has taken. Two internal sources, a system-control interrupt and a timer interrupt, each drive one fixed PCI line, which is then steered like an external request. Software programs the route registers through a plain byte read/write port.

Top module: `pirq_steer_router`

## Requirements
- R1: After reset, every route register reads 80h, `pciClaim` is 0, and `irqOut` equals `legacyIrq`.
- R2: The route registers for lines A to D sit at byte addresses 60h to 63h, and those for lines E to H at 68h to 6Bh. A write stores the full byte, and a read returns it combinationally. Reads of any other address return 0, and writes to other addresses change nothing.
- R3: With bit 7 clear, bits 3:0 of a route register give the target IRQ number. While that line's `pirqN` bit is low, `irqOut[target]` is 1.
- R4: With bit 7 of a route register set, its line drives no IRQ and claims none, whatever bits 6:0 hold.
- R5: The target values 0, 1, 2, 8 and 13 are reserved and act as disabled: such a route neither drives nor claims its IRQ. Bits 6:4 are ignored.
- R6: When two or more enabled lines target one IRQ, that output is the OR of the lines' inverted requests.
- R7: `pciClaim[n]` is 1 exactly when some enabled route targets IRQ n. A claimed IRQ ignores `legacyIrq[n]`. An unclaimed IRQ passes `legacyIrq[n]` through unchanged, with no clock delay.
- R8: `sciReq` asserts line A and `tmrReq` asserts line D. Each acts without synchronizer delay, and each is steered by that line's route register.
- R9: A register write changes `pciClaim` and `irqOut` from the clock edge that stores it. A change on `pirqN` reaches `irqOut` on the second rising edge after it, through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational on `regAddr` |
| pirqN | input | 8 | PCI request lines A (bit 0) to H (bit 7), active low |
| sciReq | input | 1 | Internal system-control interrupt, active high, drives line A |
| tmrReq | input | 1 | Internal timer interrupt, active high, drives line D |
| legacyIrq | input | 16 | Legacy device requests, active high |
| irqOut | output | 16 | Merged requests to the interrupt controller, active high |
| pciClaim | output | 16 | IRQs taken over by PCI routes |

## Verification
Read data, the legacy pass-through and the internal sources are combinational, so the bench drives them on a falling edge and samples them a moment later in the same cycle. A register write is captured on the next rising edge, so claim and output checks follow at the falling edge after it. A `pirqN` change needs two rising edges. The bench samples one falling edge later to confirm the output has not moved yet, then one more to confirm that it has. The full sweep over every line and every route byte waits for the synchronizer to settle before each comparison against the arithmetic model.

// File: rtl/pirq_steer_pkg.sv
package pirq_steer_pkg;
  localparam int PIRQ_COUNT = 8;
  localparam int IRQ_COUNT  = 16;
  localparam int IRQ_W      = $clog2(IRQ_COUNT);
  localparam int REG_W      = 8;
  localparam int DIS_BIT    = 7;

  typedef struct packed {
    logic [PIRQ_COUNT-1:0] wrStb;
    logic [PIRQ_COUNT-1:0] rdSel;
    logic [REG_W-1:0]      wrByte;
  } ctrl_stb_t;
endpackage

// File: rtl/pirq_route_ctrl.sv
module pirq_route_ctrl
  import pirq_steer_pkg::*;
#(
  parameter logic [7:0] LOW_BASE  = 8'h60,
  parameter logic [7:0] HIGH_BASE = 8'h68,
  parameter int         BANK_SIZE = 4
) (
  input  logic [7:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output ctrl_stb_t        ctrlStb
);
  logic [PIRQ_COUNT-1:0] addrHit;

  for (genvar l = 0; l < PIRQ_COUNT; l++) begin : g_dec
    localparam logic [7:0] LINE_ADDR = (l < BANK_SIZE)
      ? LOW_BASE + 8'(l) : HIGH_BASE + 8'(l - BANK_SIZE);
    assign addrHit[l] = (regAddr == LINE_ADDR);
  end

  always_comb begin
    ctrlStb.rdSel  = addrHit;
    ctrlStb.wrStb  = regWrEn ? addrHit : '0;
    ctrlStb.wrByte = regWrData;
  end
endmodule

// File: rtl/pirq_route_dp.sv
module pirq_route_dp
  import pirq_steer_pkg::*;
#(
  parameter int               SYNC_STAGES  = 2,
  parameter int               SCI_LINE     = 0,
  parameter int               TMR_LINE     = 3,
  parameter logic [IRQ_COUNT-1:0] RESERVED_MASK = 16'h2107,
  parameter logic [REG_W-1:0] RESET_VALUE  = 8'h80
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_stb_t             ctrlStb,
  input  logic [PIRQ_COUNT-1:0] pirqN,
  input  logic                  sciReq,
  input  logic                  tmrReq,
  input  logic [IRQ_COUNT-1:0]  legacyIrq,
  output logic [REG_W-1:0]      regRdData,
  output logic [IRQ_COUNT-1:0]  irqOut,
  output logic [IRQ_COUNT-1:0]  pciClaim
);
  logic [REG_W-1:0]      routeReg [PIRQ_COUNT];
  logic [PIRQ_COUNT-1:0] syncN    [SYNC_STAGES];
  logic [PIRQ_COUNT-1:0] lineActive;
  logic [PIRQ_COUNT-1:0] intMask;
  logic [IRQ_COUNT-1:0]  lineHit  [PIRQ_COUNT];

  // route registers
  for (genvar l = 0; l < PIRQ_COUNT; l++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 routeReg[l] <= RESET_VALUE;
      else if (ctrlStb.wrStb[l]) routeReg[l] <= ctrlStb.wrByte;
    end
  end

  // request synchronizer, idle value is deasserted (high)
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncN[s] <= '1;
      else if (s == 0) syncN[s] <= pirqN;
      else syncN[s] <= syncN[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    intMask = '0;
    intMask[SCI_LINE] = intMask[SCI_LINE] | sciReq;
    intMask[TMR_LINE] = intMask[TMR_LINE] | tmrReq;
  end

  assign lineActive = ~syncN[SYNC_STAGES-1] | intMask;

  // per-line target decode
  for (genvar l = 0; l < PIRQ_COUNT; l++) begin : g_route
    logic [IRQ_W-1:0] tgt;
    logic             routeOk;
    assign tgt     = routeReg[l][IRQ_W-1:0];
    assign routeOk = !routeReg[l][DIS_BIT] && !RESERVED_MASK[tgt];
    always_comb begin
      lineHit[l] = '0;
      if (routeOk) lineHit[l][tgt] = 1'b1;
    end
  end

  always_comb begin
    logic [IRQ_COUNT-1:0] claimAcc;
    logic [IRQ_COUNT-1:0] driveAcc;
    claimAcc = '0;
    driveAcc = '0;
    for (int l = 0; l < PIRQ_COUNT; l++) begin
      claimAcc |= lineHit[l];
      if (lineActive[l]) driveAcc |= lineHit[l];
    end
    pciClaim = claimAcc;
    irqOut   = driveAcc | (legacyIrq & ~claimAcc);
  end

  always_comb begin
    regRdData = '0;
    for (int l = 0; l < PIRQ_COUNT; l++)
      if (ctrlStb.rdSel[l]) regRdData |= routeReg[l];
  end
endmodule

// File: rtl/pirq_steer_router.sv
module pirq_steer_router
  import pirq_steer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SCI_LINE    = 0,
  parameter int TMR_LINE    = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic [7:0]  pirqN,
  input  logic        sciReq,
  input  logic        tmrReq,
  input  logic [15:0] legacyIrq,
  output logic [15:0] irqOut,
  output logic [15:0] pciClaim
);
  ctrl_stb_t ctrlStb;

  pirq_route_ctrl i_ctrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .ctrlStb  (ctrlStb)
  );

  pirq_route_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .SCI_LINE   (SCI_LINE),
    .TMR_LINE   (TMR_LINE)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlStb  (ctrlStb),
    .pirqN    (pirqN),
    .sciReq   (sciReq),
    .tmrReq   (tmrReq),
    .legacyIrq(legacyIrq),
    .regRdData(regRdData),
    .irqOut   (irqOut),
    .pciClaim (pciClaim)
  );
endmodule

// File: rtl/pirq_steer_checker.sv
module pirq_steer_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  regAddr,
  input logic        regWrEn,
  input logic [7:0]  regWrData,
  input logic [7:0]  regRdData,
  input logic [15:0] legacyIrq,
  input logic [15:0] irqOut,
  input logic [15:0] pciClaim
);
  logic addrMapped;
  assign addrMapped = (regAddr[7:4] == 4'h6) && !regAddr[2];

  // R7
  unclaimed_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~pciClaim) == (legacyIrq & ~pciClaim));

  // R5
  reserved_unclaimed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pciClaim & 16'h2107) == 16'h0000);

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && addrMapped) |=>
      (regAddr != $past(regAddr) || regRdData == $past(regWrData)));

  // R2
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrMapped |-> regRdData == 8'h00);

  // R9
  claim_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrEn && addrMapped) |-> $stable(pciClaim));
endmodule

bind pirq_steer_router pirq_steer_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .legacyIrq(legacyIrq),
  .irqOut   (irqOut),
  .pciClaim (pciClaim)
);

// File: tb/test_pirq_steer_router.sv
`timescale 1ns/1ps
module test_pirq_steer_router;
  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic [7:0]  pirqN = 8'hFF;
  logic        sciReq = 0;
  logic        tmrReq = 0;
  logic [15:0] legacyIrq = 16'h0000;
  logic [15:0] irqOut;
  logic [15:0] pciClaim;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  pirq_steer_router i_pirq_steer_router (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pirqN(pirqN),
    .sciReq(sciReq), .tmrReq(tmrReq), .legacyIrq(legacyIrq),
    .irqOut(irqOut), .pciClaim(pciClaim)
  );

  function automatic int lineOf(logic [7:0] a);
    if (a >= 8'h60 && a <= 8'h63) return int'(a - 8'h60);
    if (a >= 8'h68 && a <= 8'h6B) return int'(a - 8'h68) + 4;
    return -1;
  endfunction

  function automatic logic [7:0] addrOf(int l);
    return (l < 4) ? 8'(8'h60 + l) : 8'(8'h68 + l - 4);
  endfunction

  function automatic bit routeOn(logic [7:0] r);
    int t;
    t = int'(r[3:0]);
    return !r[7] && t != 0 && t != 1 && t != 2 && t != 8 && t != 13;
  endfunction

  function automatic logic [15:0] expClaim();
    logic [15:0] c;
    c = '0;
    for (int l = 0; l < 8; l++)
      if (routeOn(model[l])) c = c | (16'h1 << model[l][3:0]);
    return c;
  endfunction

  function automatic logic [15:0] expIrq();
    logic [15:0] e;
    bit act;
    e = legacyIrq & ~expClaim();
    for (int l = 0; l < 8; l++) begin
      act = !pirqN[l] || (l == 0 && sciReq) || (l == 3 && tmrReq);
      if (act && routeOn(model[l])) e = e | (16'h1 << model[l][3:0]);
    end
    return e;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [7:0] a, logic [7:0] d);
    int l;
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
    l = lineOf(a);
    if (l >= 0) model[l] = d;
  endtask

  task automatic checkOuts(string req);
    #1;
    check({req, " irqOut"}, irqOut, expIrq());
    check({req, " pciClaim"}, pciClaim, expClaim());
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < 8; l++) model[l] = 8'h80;
    legacyIrq = 16'hA5C3;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int l = 0; l < 8; l++) begin
      regAddr = addrOf(l); #1;
      check("R1 reset readback", 16'(regRdData), 16'h0080);
    end
    check("R1 claim", pciClaim, 16'h0000);
    check("R1 passthrough", irqOut, 16'hA5C3);

    // R2 address map: all addresses readback, unmapped writes ignored
    wrReg(8'h62, 8'h0B);
    wrReg(8'h64, 8'h05);
    wrReg(8'h6C, 8'h06);
    wrReg(8'h5F, 8'h07);
    wrReg(8'h6A, 8'h4E);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      regAddr = 8'(a); #1;
      check("R2 read map", 16'(regRdData),
            (lineOf(8'(a)) >= 0) ? 16'(model[lineOf(8'(a))]) : 16'h0000);
    end
    checkOuts("R2 unmapped write no effect");
    wrReg(8'h62, 8'h80);
    wrReg(8'h6A, 8'h80);

    // R3 R4 R5 sweep: every line, every byte, line asserted
    legacyIrq = 16'hFFFF;
    pirqN = 8'h00;
    for (int l = 0; l < 8; l++) begin
      for (int v = 0; v < 256; v++) begin
        wrReg(addrOf(l), 8'(v));
        @(negedge clk);
        checkOuts(model[l][7] ? "R4 disable" :
                  routeOn(model[l]) ? "R3 steer" : "R5 reserved");
      end
      wrReg(addrOf(l), 8'h80);
    end

    // R9 timing of write and of pirq sync
    pirqN = 8'hFF; legacyIrq = 16'h0000;
    repeat (3) @(negedge clk);
    @(negedge clk);
    regAddr = 8'h60; regWrData = 8'h05; regWrEn = 1;
    #1 check("R9 before write edge", pciClaim, 16'h0000);
    @(negedge clk);
    regWrEn = 0; model[0] = 8'h05;
    #1 check("R9 claim after write edge", pciClaim, 16'h0020);
    pirqN[0] = 0;
    @(negedge clk); #1;
    check("R9 one edge, not yet", irqOut, 16'h0000);
    @(negedge clk); #1;
    check("R9 two edges, visible", irqOut, 16'h0020);

    // R6 shared routing: A, C, E to IRQ 11
    pirqN = 8'hFF;
    wrReg(8'h60, 8'h0B); wrReg(8'h62, 8'h0B); wrReg(8'h68, 8'h0B);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      pirqN = {3'b111, ~p[2], 1'b1, ~p[1], 1'b1, ~p[0]};
      repeat (3) @(negedge clk);
      checkOuts("R6 shared OR");
      check("R6 irq11", 16'(irqOut[11]), 16'(p != 0));
    end

    // R7 legacy masking with varied patterns
    pirqN = 8'hFF;
    wrReg(8'h69, 8'h03); wrReg(8'h6B, 8'h0F);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      legacyIrq = 16'(k * 16'h1111) ^ 16'h5A3C;
      #1 checkOuts("R7 legacy mask");
    end

    // R8 internal sources
    for (int l = 0; l < 8; l++) wrReg(addrOf(l), 8'h80);
    wrReg(8'h60, 8'h09); wrReg(8'h63, 8'h0A);
    legacyIrq = 16'h0000;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      sciReq = s[0]; tmrReq = s[1];
      #1 checkOuts("R8 internal");
      check("R8 sci irq9", 16'(irqOut[9]), 16'(s[0]));
      check("R8 tmr irq10", 16'(irqOut[10]), 16'(s[1]));
    end
    sciReq = 0; tmrReq = 0;
    wrReg(8'h60, 8'h80);
    @(negedge clk);
    sciReq = 1;
    #1 checkOuts("R8 sci with line disabled");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule